// File: doc/BRIEF.md
# Write-Protection Command Sequence Guard

This block sits after a page-load controller in an electrically erasable memory. It watches every captured byte load and looks for short address/data command patterns. Each byte load is a strobe with an address and a data byte. The guard keeps a persistent protection flag and decides, load by load, whether a byte may go on to the page buffer. It raises a self-timed chip-erase request when the erase pattern arrives. Command bytes are never passed on. A byte that breaks a pattern part-way is treated as an ordinary write.

A page operation is a run of loads in which each load follows the previous one within `LOAD_WIN` clock cycles. The operation closes on the first cycle that passes that limit with no load. There are three command patterns, and all of them share the opening pair `AAh@ADDR_A` and `55h@ADDR_B`. A third byte of `A0h@ADDR_A` arms protection. If the block is already protected, that same three-byte pattern instead opens the rest of the current page operation for writing. A six-byte pattern with `80h@ADDR_A` as its third byte, followed by `AAh@ADDR_A`, `55h@ADDR_B`, and a final byte, does one of two things. A final byte of `20h@ADDR_A` drops protection. A final byte of `10h@ADDR_A` starts a chip erase.

Top module: `wp_cmd_guard`

## Requirements
- R1: While reset is held and on the first cycle after it, `protect_on`, `store_en`, `erase_start` and `erase_busy` are all 0.
- R2: When the block is unprotected, a load that is not consumed as a command byte produces `store_en`=1 in the next cycle, with `store_addr`/`store_data` equal to that load's address and data. `store_en` is never 1 without a load in the previous cycle.
- R3: The arm pattern is `AAh@ADDR_A`, `55h@ADDR_B`, `A0h@ADDR_A` (defaults `5555h`, `2AAAh`), given in that order. Its three bytes are never stored. Loads later in the same page operation are data.
- R4: After an arm pattern given while unprotected, `protect_on` rises exactly `WC_CYC` cycles after the page operation closes. The operation closes `LOAD_WIN` cycles after its last load.
- R5: While protected, a load is not stored unless the arm pattern appeared earlier in the same page operation. After that pattern, the remaining loads of the operation are stored.
- R6: The six-byte pattern `AAh@A`, `55h@B`, `80h@A`, `AAh@A`, `55h@B`, `20h@A` clears `protect_on` in the cycle after its last byte. None of its bytes are stored.
- R7: The six-byte pattern ending in `10h@A` (same first five bytes as R6) gives a one-cycle `erase_start` in the cycle after its last byte. `erase_busy` is then 1 for `ERASE_CYC` cycles. Loads during `erase_busy` are dropped. `protect_on` is left unchanged.
- R8: A load that does not match the expected next byte of a pattern returns the matcher to idle. That load is then handled as an ordinary write under the current protection state.
- R9: A gap of more than `LOAD_WIN` cycles between two loads closes the page operation and discards any partial pattern.
- R10: Pattern addresses are compared on the low `CMD_AW` (15) address bits only. Higher address bits are ignored.
- R11: The write permission opened by R5 ends when its page operation closes. The next operation is protected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Byte-load strobe, one cycle per byte |
| load_addr | input | AW | Address of the loaded byte |
| load_data | input | 8 | Loaded data byte |
| protect_on | output | 1 | Persistent write-protection state |
| store_en | output | 1 | Previous cycle's load may be committed |
| store_addr | output | AW | Address to commit |
| store_data | output | 8 | Data to commit |
| erase_start | output | 1 | One-cycle chip-erase request |
| erase_busy | output | 1 | Self-timed erase in progress |

## Verification
Several rules hold on every cycle, and the bound checker watches them continuously. A consumed command byte never yields a store. A locked, unopened load is dropped. `protect_on` can rise only off the arming timer, and the disable pattern always clears it. The erase request is a single cycle, and loads during an erase are dropped without touching the protection state. Other behaviour depends on a specific history of loads and can only be shown by the bench's scenarios. This covers the exact arming delay after the page closes, a broken or timed-out partial pattern falling back to an ordinary write, matching on only the low address bits, and the unlock ending with its page operation.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_S1,
    SEQ_S2,
    SEQ_L3,
    SEQ_L4,
    SEQ_L5
  } seq_state_t;

  localparam logic [7:0] CODE_LEAD = 8'hAA;
  localparam logic [7:0] CODE_ECHO = 8'h55;
  localparam logic [7:0] CODE_SET  = 8'hA0;
  localparam logic [7:0] CODE_EXT  = 8'h80;
  localparam logic [7:0] CODE_CLR  = 8'h20;
  localparam logic [7:0] CODE_WIPE = 8'h10;

  // A load equals one pattern step when both the compared address and the data agree
  function automatic logic step_is(input logic [31:0] addr, input logic [7:0] data,
                                   input logic [31:0] want_addr, input logic [7:0] want_data);
    return (addr == want_addr) && (data == want_data);
  endfunction

  // Next value of a down-counter that reloads on start
  function automatic logic [31:0] count_next(input logic start, input logic [31:0] cur,
                                             input logic [31:0] reload);
    if (start) return reload;
    if (cur != 32'd0) return cur - 32'd1;
    return 32'd0;
  endfunction

endpackage

// File: rtl/wp_seq_matcher.sv
module wp_seq_matcher
  import wp_guard_pkg::*;
#(
  parameter int CMD_AW = 15,
  parameter logic [CMD_AW-1:0] ADDR_A = 15'h5555,
  parameter logic [CMD_AW-1:0] ADDR_B = 15'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              clr,
  input  logic [CMD_AW-1:0] addr,
  input  logic [7:0]        data,
  output logic              cmd_hit,
  output logic              done_set,
  output logic              done_clr,
  output logic              done_wipe
);

  seq_state_t st, st_nxt;
  logic is_lead, is_echo, is_set, is_ext, is_clr, is_wipe;
  logic hit;

  always_comb begin
    is_lead = step_is(32'(addr), data, 32'(ADDR_A), CODE_LEAD);
    is_echo = step_is(32'(addr), data, 32'(ADDR_B), CODE_ECHO);
    is_set  = step_is(32'(addr), data, 32'(ADDR_A), CODE_SET);
    is_ext  = step_is(32'(addr), data, 32'(ADDR_A), CODE_EXT);
    is_clr  = step_is(32'(addr), data, 32'(ADDR_A), CODE_CLR);
    is_wipe = step_is(32'(addr), data, 32'(ADDR_A), CODE_WIPE);
  end

  always_comb begin
    st_nxt    = SEQ_IDLE;
    hit       = 1'b0;
    done_set  = 1'b0;
    done_clr  = 1'b0;
    done_wipe = 1'b0;
    case (st)
      SEQ_IDLE: if (is_lead) begin hit = 1'b1; st_nxt = SEQ_S1; end
      SEQ_S1:   if (is_echo) begin hit = 1'b1; st_nxt = SEQ_S2; end
      SEQ_S2: begin
        if (is_set) begin
          hit = 1'b1;
          done_set = step_en;
        end else if (is_ext) begin
          hit = 1'b1;
          st_nxt = SEQ_L3;
        end
      end
      SEQ_L3:   if (is_lead) begin hit = 1'b1; st_nxt = SEQ_L4; end
      SEQ_L4:   if (is_echo) begin hit = 1'b1; st_nxt = SEQ_L5; end
      SEQ_L5: begin
        if (is_clr) begin
          hit = 1'b1;
          done_clr = step_en;
        end else if (is_wipe) begin
          hit = 1'b1;
          done_wipe = step_en;
        end
      end
      default: st_nxt = SEQ_IDLE;
    endcase
    cmd_hit = hit && step_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       st <= SEQ_IDLE;
    else if (clr)     st <= SEQ_IDLE;
    else if (step_en) st <= st_nxt;
  end

endmodule

// File: rtl/wp_load_window.sv
module wp_load_window
  import wp_guard_pkg::*;
#(
  parameter int LOAD_WIN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic kill,
  output logic open_o,
  output logic expire
);

  localparam int CW = $clog2(LOAD_WIN + 1);

  logic [CW-1:0] cnt;
  logic [31:0]   cnt_wide;

  assign expire   = open_o && (cnt == '0) && !load;
  assign cnt_wide = count_next(load, 32'(cnt), 32'(LOAD_WIN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_o <= 1'b0;
      cnt    <= '0;
    end else if (kill) begin
      open_o <= 1'b0;
      cnt    <= '0;
    end else if (load) begin
      open_o <= 1'b1;
      cnt    <= cnt_wide[CW-1:0];
    end else if (expire) begin
      open_o <= 1'b0;
    end else if (open_o) begin
      cnt    <= cnt_wide[CW-1:0];
    end
  end

endmodule

// File: rtl/wp_countdown.sv
module wp_countdown
  import wp_guard_pkg::*;
#(
  parameter int CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  output logic busy,
  output logic fin
);

  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] cnt;
  logic [31:0]   cnt_wide;

  assign fin      = busy && (cnt == '0) && !cancel;
  assign cnt_wide = count_next(start, 32'(cnt), 32'(CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (cancel) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= cnt_wide[CW-1:0];
    end else if (fin) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt  <= cnt_wide[CW-1:0];
    end
  end

endmodule

// File: rtl/wp_cmd_guard.sv
module wp_cmd_guard
  import wp_guard_pkg::*;
#(
  parameter int AW        = 17,
  parameter int CMD_AW    = 15,
  parameter logic [CMD_AW-1:0] ADDR_A = 15'h5555,
  parameter logic [CMD_AW-1:0] ADDR_B = 15'h2AAA,
  parameter int LOAD_WIN  = 16,
  parameter int WC_CYC    = 20,
  parameter int ERASE_CYC = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_valid,
  input  logic [AW-1:0] load_addr,
  input  logic [7:0]    load_data,
  output logic          protect_on,
  output logic          store_en,
  output logic [AW-1:0] store_addr,
  output logic [7:0]    store_data,
  output logic          erase_start,
  output logic          erase_busy
);

  // named internal events
  logic accept;
  logic scan_en;
  logic cmd_byte;
  logic done_set, done_clr, done_wipe;
  logic page_open, page_close;
  logic unlocked;
  logic arm_pend, arm_go, arm_busy, arm_fin;
  logic erase_fin;
  logic store_ok;

  assign accept   = load_valid && !erase_busy;
  assign scan_en  = accept && !unlocked;

  wp_seq_matcher #(
    .CMD_AW (CMD_AW),
    .ADDR_A (ADDR_A),
    .ADDR_B (ADDR_B)
  ) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (scan_en),
    .clr       (page_close),
    .addr      (load_addr[CMD_AW-1:0]),
    .data      (load_data),
    .cmd_hit   (cmd_byte),
    .done_set  (done_set),
    .done_clr  (done_clr),
    .done_wipe (done_wipe)
  );

  wp_load_window #(
    .LOAD_WIN (LOAD_WIN)
  ) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .kill   (done_wipe),
    .open_o (page_open),
    .expire (page_close)
  );

  assign arm_go = page_close && arm_pend;

  wp_countdown #(
    .CYCLES (WC_CYC)
  ) u_arm (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (arm_go),
    .cancel (done_clr),
    .busy   (arm_busy),
    .fin    (arm_fin)
  );

  wp_countdown #(
    .CYCLES (ERASE_CYC)
  ) u_erase (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (done_wipe),
    .cancel (1'b0),
    .busy   (erase_busy),
    .fin    (erase_fin)
  );

  assign store_ok = accept && !cmd_byte && (!protect_on || unlocked);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      arm_pend <= 1'b0;
      protect_on <= 1'b0;
    end else begin
      if (page_close || done_wipe) unlocked <= 1'b0;
      else if (done_set)           unlocked <= 1'b1;

      if (done_clr)                     arm_pend <= 1'b0;
      else if (done_set && !protect_on) arm_pend <= 1'b1;
      else if (page_close)              arm_pend <= 1'b0;

      if (done_clr)     protect_on <= 1'b0;
      else if (arm_fin) protect_on <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_en    <= 1'b0;
      store_addr  <= '0;
      store_data  <= '0;
      erase_start <= 1'b0;
    end else begin
      store_en    <= store_ok;
      erase_start <= done_wipe;
      if (store_ok) begin
        store_addr <= load_addr;
        store_data <= load_data;
      end
    end
  end

endmodule

// File: rtl/wp_cmd_guard_chk.sv
module wp_cmd_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic load_valid,
  input logic protect_on,
  input logic store_en,
  input logic erase_start,
  input logic erase_busy,
  input logic unlocked,
  input logic cmd_byte,
  input logic done_set,
  input logic done_clr,
  input logic done_wipe,
  input logic arm_fin,
  input logic arm_busy
);

  assert_store_needs_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    store_en |-> $past(load_valid));

  assert_cmd_not_stored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_byte |=> !store_en);

  assert_one_pattern_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_set, done_clr, done_wipe}));

  assert_protect_from_timer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(protect_on) |-> $past(arm_fin));

  assert_locked_load_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && !erase_busy && protect_on && !unlocked) |=> !store_en);

  assert_disable_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_clr |=> !protect_on);

  assert_erase_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  assert_erase_drops_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && erase_busy) |=> !store_en);

  assert_erase_keeps_protect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_busy && !arm_busy) |=> $stable(protect_on));

endmodule

bind wp_cmd_guard wp_cmd_guard_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_valid  (load_valid),
  .protect_on  (protect_on),
  .store_en    (store_en),
  .erase_start (erase_start),
  .erase_busy  (erase_busy),
  .unlocked    (unlocked),
  .cmd_byte    (cmd_byte),
  .done_set    (done_set),
  .done_clr    (done_clr),
  .done_wipe   (done_wipe),
  .arm_fin     (arm_fin),
  .arm_busy    (arm_busy)
);

// File: tb/test_wp_cmd_guard.sv
module test_wp_cmd_guard;
  localparam int AW = 17;
  localparam int LW = 16;
  localparam int WC = 20;
  localparam int EC = 40;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          load_valid;
  logic [AW-1:0] load_addr;
  logic [7:0]    load_data;
  logic          protect_on, store_en, erase_start, erase_busy;
  logic [AW-1:0] store_addr;
  logic [7:0]    store_data;

  wp_cmd_guard #(.AW(AW), .LOAD_WIN(LW), .WC_CYC(WC), .ERASE_CYC(EC)) i_wp_cmd_guard (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_addr(load_addr),
    .load_data(load_data), .protect_on(protect_on), .store_en(store_en),
    .store_addr(store_addr), .store_data(store_data), .erase_start(erase_start),
    .erase_busy(erase_busy)
  );

  typedef struct {
    bit            en;
    logic [AW-1:0] a;
    logic [7:0]    d;
    string         req;
  } exp_t;

  exp_t sbq[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   lv_q = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) lv_q <= load_valid;

  // monitor: one expected item per accepted strobe
  always @(negedge clk) begin
    if (rst_n) begin
      if (lv_q) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R2", "scoreboard empty", 1, 0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check(store_en == e.en, e.req, "store_en", store_en, e.en);
          if (e.en) begin
            check(store_addr == e.a, e.req, "store_addr", store_addr, e.a);
            check(store_data == e.d, e.req, "store_data", store_data, e.d);
          end
        end
      end else if (store_en) begin
        check(1'b0, "R2", "store without load", 1, 0);
      end
    end
  end

  task automatic load(input logic [AW-1:0] a, input logic [7:0] d, input bit en,
                      input string req);
    exp_t e;
    e.en = en; e.a = a; e.d = d; e.req = req;
    sbq.push_back(e);
    load_valid = 1'b1;
    load_addr  = a;
    load_data  = d;
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm_seq(input string req);
    load(17'h05555, 8'hAA, 1'b0, req);
    load(17'h02AAA, 8'h55, 1'b0, req);
    load(17'h05555, 8'hA0, 1'b0, req);
  endtask

  task automatic long_seq(input logic [7:0] last, input string req);
    load(17'h05555, 8'hAA, 1'b0, req);
    load(17'h02AAA, 8'h55, 1'b0, req);
    load(17'h05555, 8'h80, 1'b0, req);
    load(17'h05555, 8'hAA, 1'b0, req);
    load(17'h02AAA, 8'h55, 1'b0, req);
    load(17'h05555, last,  1'b0, req);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_valid = 1'b0; load_addr = '0; load_data = '0;
    idle(3);
    // R1: outputs while reset held
    check(!protect_on && !store_en && !erase_start && !erase_busy, "R1", "reset outputs",
          {protect_on, store_en, erase_start, erase_busy}, 0);
    rst_n = 1'b1;
    idle(1);
    check(!protect_on && !store_en && !erase_start && !erase_busy, "R1", "after reset",
          {protect_on, store_en, erase_start, erase_busy}, 0);

    // R2: plain writes while unprotected
    load(17'h00010, 8'h3C, 1'b1, "R2");
    load(17'h1FFFF, 8'h00, 1'b1, "R2");
    load(17'h05555, 8'h12, 1'b1, "R2");
    idle(LW + 2);

    // R8: broken pattern, unprotected; breaking byte is stored
    load(17'h05555, 8'hAA, 1'b0, "R8");
    load(17'h02AAA, 8'h55, 1'b0, "R8");
    load(17'h05555, 8'h33, 1'b1, "R8");
    idle(LW + 2);

    // R9: gap beyond window discards the partial pattern
    load(17'h05555, 8'hAA, 1'b0, "R9");
    load(17'h02AAA, 8'h55, 1'b0, "R9");
    idle(LW + 1);
    load(17'h05555, 8'hA0, 1'b1, "R9");
    idle(LW + WC + 4);
    check(!protect_on, "R9", "protect after timed-out pattern", protect_on, 0);

    // R3 / R10: arm pattern with high address bits set, then data in same page
    load(17'h1D555, 8'hAA, 1'b0, "R10");
    load(17'h12AAA, 8'h55, 1'b0, "R10");
    load(17'h05555, 8'hA0, 1'b0, "R3");
    load(17'h00200, 8'h5A, 1'b1, "R3");
    // R4: close after LW idle cycles, protect WC cycles later
    idle(LW + WC - 1);
    check(!protect_on, "R4", "protect one cycle early", protect_on, 0);
    idle(1);
    check(protect_on, "R4", "protect on time", protect_on, 1);

    // R5: locked write dropped, opened page stored
    load(17'h00300, 8'h77, 1'b0, "R5");
    idle(LW + 2);
    arm_seq("R5");
    load(17'h00301, 8'hC3, 1'b1, "R5");
    load(17'h00302, 8'h3C, 1'b1, "R5");
    idle(LW + 2);
    check(protect_on, "R5", "protect kept", protect_on, 1);
    // R11: next page locked again
    load(17'h00303, 8'h99, 1'b0, "R11");
    idle(LW + 2);

    // R8: broken pattern while protected is dropped
    load(17'h05555, 8'hAA, 1'b0, "R8");
    load(17'h00100, 8'h12, 1'b0, "R8");
    idle(LW + 2);

    // R7: chip erase while protected
    long_seq(8'h10, "R7");
    check(erase_start && erase_busy, "R7", "erase start", {erase_start, erase_busy}, 3);
    load(17'h00400, 8'h01, 1'b0, "R7");
    check(!erase_start, "R7", "erase pulse width", erase_start, 0);
    idle(EC - 2);
    check(erase_busy, "R7", "busy last cycle", erase_busy, 1);
    idle(1);
    check(!erase_busy, "R7", "busy released", erase_busy, 0);
    check(protect_on, "R7", "protect unchanged", protect_on, 1);
    idle(LW + 2);

    // R6: disable pattern, then a write is stored
    long_seq(8'h20, "R6");
    check(!protect_on, "R6", "protect cleared", protect_on, 0);
    load(17'h00500, 8'hE7, 1'b1, "R6");
    idle(4);

    check(sbq.size() == 0, "R2", "scoreboard drained", sbq.size(), 0);
    summary();
    $finish;
  end

endmodule